// File: doc/BRIEF.md
# Multi-Channel Prescaled PWM Generator

This block produces a bank of pulse-width-modulated outputs that share one time base. A prescaler divides the input clock into ticks, and a step counter advances once per tick. Each channel compares the step count against its own duty value and drives its output high while the count is below that value. Every channel has an enable bit.

Software sets the block up through a simple synchronous register port. The port has one write path and one read path, and reads return data one clock after the address is presented. A duty write always lands in a per-channel shadow register. Channels chosen by a build-time mask can run in a period-aligned mode, which is switched on once through a sticky mode bit. In that mode, such a channel copies its shadow value into its working duty only when the step counter wraps. Any other channel, and any channel while the mode is off, picks up a duty write on the following clock.

Register addresses are as follows. Prescale is at 0 and step limit at 1. The enable bytes start at 2: address 2 holds bits for channels 0–7 and address 3 holds channels 8–15, where bit i selects the channel at position i of that group. The mode bit is bit 0 of address 6. Channel n's duty sits at address 16+n.

Top module: `pwm_bank`

## Requirements
- R1: With prescale P and step limit S, every channel's output repeats every (P+1)·(S+1) clock cycles.
- R2: An enabled channel with working duty D is high for min(D, S+1)·(P+1) cycles of each period. A duty above S therefore gives a constant high, while S=0xFF with D=0xFF gives 255 of 256 steps high.
- R3: A channel whose enable bit is 0 holds its output low whatever its duty.
- R4: Enable bits are written and read at address 2 (channels 0–7, bit i = channel i) and address 3 (channels 8–15, bit i = channel 8+i).
- R5: Reading address 16+n returns the duty value last written to channel n, even while that value is still waiting to take effect.
- R6: A channel outside the sync mask, or any channel while the mode bit is 0, applies a duty write on the next clock, so the following full period already uses it.
- R7: Writing a value with bit 0 set to address 6 sets the mode bit. Writing 0 there leaves it set. Address 6 reads back the bit in position 0.
- R8: With the mode bit set, a masked channel keeps its working duty until the step counter wraps, and this holds for every later write, not only the first.
- R9: Synchronous reset clears the counters, prescale, step limit, enables, shadow and working duties and the mode bit, and drives all outputs low.
- R10: Read data for an address appears on rd_data one clock after rd_addr is presented. Prescale and step limit read back at addresses 0 and 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 5 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 5 | Read address |
| rd_data | output | 8 | Registered read data |
| pwm_out | output | 16 | Registered channel outputs |

## Verification
The bench measures the high time over a whole period and the distance from one rising edge to the next for several prescale, step and duty settings. These settings include a duty above the step limit and the limit 0xFF, where a design that mishandles the off-by-one in either counter shows a wrong count or a false constant high. It aligns a measurement window to the start of a period, then rewrites a masked channel's duty inside that window. A design that applied the value at once, or only for the first write after the mode was set, would show the new width one period too early. It also checks that writing 0 does not clear the mode bit, that disabled channels stay low, and that the shadow value reads back before it takes effect.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;
  localparam int ADDR_W = 5;
  localparam logic [ADDR_W-1:0] ADR_PRESCALE  = 5'd0;
  localparam logic [ADDR_W-1:0] ADR_STEPS     = 5'd1;
  localparam logic [ADDR_W-1:0] ADR_EN_BASE   = 5'd2;
  localparam logic [ADDR_W-1:0] ADR_SYNC      = 5'd6;
  localparam logic [ADDR_W-1:0] ADR_DUTY_BASE = 5'd16;
endpackage

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] prescale,
  input  logic [DW-1:0] steps,
  output logic          tick,
  output logic          wrap,
  output logic [DW-1:0] step
);
  logic [DW-1:0] pre_q;
  logic [DW-1:0] step_q;

  // ">=" lets the counters recover at once when a limit is lowered mid-count
  assign tick = (pre_q >= prescale);
  assign wrap = tick && (step_q >= steps);
  assign step = step_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_q  <= '0;
      step_q <= '0;
    end else begin
      if (tick) pre_q <= '0;
      else      pre_q <= pre_q + 1'b1;
      if (wrap)      step_q <= '0;
      else if (tick) step_q <= step_q + 1'b1;
    end
  end
endmodule

// File: rtl/pwm_regs.sv
module pwm_regs
  import pwm_bank_pkg::*;
#(
  parameter int NCH = 16,
  parameter int DW  = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr_en,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [DW-1:0]           wr_data,
  input  logic [ADDR_W-1:0]       rd_addr,
  output logic [DW-1:0]           rd_data,
  output logic [DW-1:0]           prescale,
  output logic [DW-1:0]           steps,
  output logic [NCH-1:0]          en,
  output logic                    sync_mode,
  output logic [NCH-1:0][DW-1:0]  shadow,
  output logic [NCH-1:0]          duty_stb
);
  localparam int NEN = (NCH + DW - 1) / DW;

  logic [DW-1:0]         pre_q, steps_q;
  logic [NEN*DW-1:0]     en_q;
  logic                  sync_q;
  logic [NCH-1:0][DW-1:0] shadow_q;
  logic [DW-1:0]         rd_mux, rd_q;

  for (genvar i = 0; i < NCH; i++) begin : g_stb
    assign duty_stb[i] = wr_en && (wr_addr == ADR_DUTY_BASE + ADDR_W'(i));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_q    <= '0;
      steps_q  <= '0;
      en_q     <= '0;
      sync_q   <= 1'b0;
      shadow_q <= '0;
    end else begin
      if (wr_en && wr_addr == ADR_PRESCALE) pre_q   <= wr_data;
      if (wr_en && wr_addr == ADR_STEPS)    steps_q <= wr_data;
      if (wr_en && wr_addr == ADR_SYNC && wr_data[0]) sync_q <= 1'b1;
      for (int k = 0; k < NEN; k++) begin
        if (wr_en && wr_addr == ADR_EN_BASE + ADDR_W'(k))
          en_q[k*DW +: DW] <= wr_data;
      end
      for (int i = 0; i < NCH; i++) begin
        if (duty_stb[i]) shadow_q[i] <= wr_data;
      end
    end
  end

  always_comb begin
    rd_mux = '0;
    if (rd_addr == ADR_PRESCALE) rd_mux = pre_q;
    if (rd_addr == ADR_STEPS)    rd_mux = steps_q;
    if (rd_addr == ADR_SYNC)     rd_mux = DW'(sync_q);
    for (int k = 0; k < NEN; k++) begin
      if (rd_addr == ADR_EN_BASE + ADDR_W'(k)) rd_mux = en_q[k*DW +: DW];
    end
    for (int i = 0; i < NCH; i++) begin
      if (rd_addr == ADR_DUTY_BASE + ADDR_W'(i)) rd_mux = shadow_q[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_q <= '0;
    else     rd_q <= rd_mux;
  end

  assign rd_data   = rd_q;
  assign prescale  = pre_q;
  assign steps     = steps_q;
  assign en        = en_q[NCH-1:0];
  assign sync_mode = sync_q;
  assign shadow    = shadow_q;
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel #(
  parameter int DW      = 8,
  parameter bit IS_SYNC = 1'b0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          duty_stb,
  input  logic [DW-1:0] wr_data,
  input  logic [DW-1:0] shadow,
  input  logic          sync_mode,
  input  logic          wrap,
  input  logic          enable,
  input  logic [DW-1:0] step,
  output logic [DW-1:0] duty_act,
  output logic          pwm
);
  logic          hold;
  logic [DW-1:0] act_q;
  logic          pwm_q;

  assign hold = IS_SYNC && sync_mode;

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q <= '0;
      pwm_q <= 1'b0;
    end else begin
      if (hold) begin
        if (wrap) act_q <= shadow;
      end else if (duty_stb) begin
        act_q <= wr_data;
      end
      pwm_q <= enable && (step < act_q);
    end
  end

  assign duty_act = act_q;
  assign pwm      = pwm_q;
endmodule

// File: rtl/pwm_bank.sv
module pwm_bank
  import pwm_bank_pkg::*;
#(
  parameter int             NCH       = 16,
  parameter int             DW        = 8,
  parameter logic [NCH-1:0] SYNC_MASK = 16'hFF00
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DW-1:0]     wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DW-1:0]     rd_data,
  output logic [NCH-1:0]    pwm_out
);
  logic [DW-1:0]          prescale, steps, step;
  logic                   tick, wrap, sync_mode;
  logic [NCH-1:0]         en, duty_stb;
  logic [NCH-1:0][DW-1:0] shadow, act_duty;

  pwm_regs #(.NCH(NCH), .DW(DW)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .prescale(prescale), .steps(steps),
    .en(en), .sync_mode(sync_mode), .shadow(shadow), .duty_stb(duty_stb)
  );

  pwm_timebase #(.DW(DW)) u_tb (
    .clk(clk), .rst(rst), .prescale(prescale), .steps(steps),
    .tick(tick), .wrap(wrap), .step(step)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    pwm_channel #(.DW(DW), .IS_SYNC(SYNC_MASK[i])) u_ch (
      .clk(clk), .rst(rst), .duty_stb(duty_stb[i]), .wr_data(wr_data),
      .shadow(shadow[i]), .sync_mode(sync_mode), .wrap(wrap), .enable(en[i]),
      .step(step), .duty_act(act_duty[i]), .pwm(pwm_out[i])
    );
  end
endmodule

// File: rtl/pwm_bank_chk.sv
module pwm_bank_chk #(
  parameter int             NCH       = 16,
  parameter int             DW        = 8,
  parameter logic [NCH-1:0] SYNC_MASK = 16'hFF00
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   tick,
  input logic                   wrap,
  input logic [DW-1:0]          step,
  input logic [NCH-1:0]         en,
  input logic                   sync_mode,
  input logic [NCH-1:0][DW-1:0] act_duty,
  input logic [NCH-1:0]         pwm_out
);
  a_r1_step_waits_tick: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(step));
  a_r1_wrap_restarts: assert property (@(posedge clk) disable iff (rst)
    wrap |=> step == '0);
  a_r7_mode_sticky: assert property (@(posedge clk) disable iff (rst)
    sync_mode |=> sync_mode);
  a_r9_reset_low: assert property (@(posedge clk)
    rst |=> pwm_out == '0);

  for (genvar i = 0; i < NCH; i++) begin : g_c
    a_r3_disabled_low: assert property (@(posedge clk) disable iff (rst)
      !en[i] |=> !pwm_out[i]);
    a_r2_high_below_duty: assert property (@(posedge clk) disable iff (rst)
      (en[i] && step < act_duty[i]) |=> pwm_out[i]);
    if (SYNC_MASK[i]) begin : g_s
      a_r8_hold_until_wrap: assert property (@(posedge clk) disable iff (rst)
        (sync_mode && !wrap) |=> $stable(act_duty[i]));
    end
  end
endmodule

bind pwm_bank pwm_bank_chk #(.NCH(NCH), .DW(DW), .SYNC_MASK(SYNC_MASK)) u_chk (
  .clk(clk), .rst(rst), .tick(tick), .wrap(wrap), .step(step), .en(en),
  .sync_mode(sync_mode), .act_duty(act_duty), .pwm_out(pwm_out)
);

// File: tb/tb_pwm_bank.sv
module tb_pwm_bank;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 7;
  // prescale, steps, duty, expected high cycles, expected period
  localparam int VEC [NV][5] = '{
    '{0,   9,   3,   3,  10},
    '{3,   9,   5,  20,  40},
    '{1, 254, 255, 510, 510},
    '{0, 255, 255, 255, 256},
    '{2,   4,   0,   0,  15},
    '{0,   4,   9,   5,   5},
    '{4,   2,   1,   5,  15}
  };

  logic       clk = 0, rst = 1, wr_en = 0;
  logic [4:0] wr_addr = 0, rd_addr = 0;
  logic [7:0] wr_data = 0, rd_data;
  logic [15:0] pwm_out;
  int tests = 0, fails = 0;

  pwm_bank dut (.clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
                .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
                .pwm_out(pwm_out));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [4:0] a, output int d);
    @(negedge clk); rd_addr = a;
    @(negedge clk); d = int'(rd_data);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic count_hi(input int ch, input int n, output int c);
    c = 0;
    for (int i = 0; i < n; i++) begin
      if (pwm_out[ch]) c++;
      @(negedge clk);
    end
  endtask

  task automatic wait_rise(input int ch);
    int g = 0;
    @(negedge clk);
    while (pwm_out[ch] !== 1'b0 && g < 3000) begin @(negedge clk); g++; end
    while (pwm_out[ch] !== 1'b1 && g < 6000) begin @(negedge clk); g++; end
  endtask

  task automatic rise_to_rise(input int ch, output int n);
    logic prev = 1'b1;
    n = 0;
    wait_rise(ch);
    for (int g = 0; g < 3000; g++) begin
      @(negedge clk); n++;
      if (pwm_out[ch] && !prev) break;
      prev = pwm_out[ch];
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int d, c1, c2;
    idle(4);
    rst = 0;
    // R9: reset state
    check("R9 outputs", int'(pwm_out), 0);
    rd(5'd0, d);  check("R9 prescale", d, 0);
    rd(5'd1, d);  check("R9 steps", d, 0);
    rd(5'd2, d);  check("R9 en lo", d, 0);
    rd(5'd3, d);  check("R9 en hi", d, 0);
    rd(5'd6, d);  check("R9 mode", d, 0);
    rd(5'd16, d); check("R9 duty", d, 0);

    // R10: readback of limits
    wr(5'd0, 8'h5A); rd(5'd0, d); check("R10 prescale rd", d, 8'h5A);
    wr(5'd1, 8'hA5); rd(5'd1, d); check("R10 steps rd", d, 8'hA5);

    // R4: enable channel 0 and channel 9
    wr(5'd2, 8'h01); wr(5'd3, 8'h02);
    rd(5'd2, d); check("R4 en lo", d, 1);
    rd(5'd3, d); check("R4 en hi", d, 2);
    wr(5'd17, 8'd3); // channel 1 stays disabled

    for (int v = 0; v < NV; v++) begin
      wr(5'd0, 8'(VEC[v][0]));
      wr(5'd1, 8'(VEC[v][1]));
      wr(5'd16, 8'(VEC[v][2]));
      wr(5'd25, 8'(VEC[v][2]));
      idle(2*VEC[v][4] + 4);
      count_hi(0, VEC[v][4], c1); check("R2 ch0 high time", c1, VEC[v][3]);
      count_hi(9, VEC[v][4], c1); check("R6 ch9 mode off", c1, VEC[v][3]);
      if (VEC[v][3] > 0 && VEC[v][3] < VEC[v][4]) begin
        rise_to_rise(0, c1); check("R1 period", c1, VEC[v][4]);
      end
    end

    // R3: disabled channels stay low
    count_hi(1, 30, c1); check("R3 ch1 disabled", c1, 0);
    wr(5'd2, 8'h00); idle(4);
    count_hi(0, 30, c1); check("R3 ch0 disabled", c1, 0);

    // R7: sticky mode bit
    wr(5'd0, 8'd3); wr(5'd1, 8'd9); wr(5'd25, 8'd5); idle(90);
    wr(5'd6, 8'h01); rd(5'd6, d); check("R7 mode set", d, 1);
    wr(5'd6, 8'h00); rd(5'd6, d); check("R7 mode kept", d, 1);

    // R8: masked channel waits for wrap, on every write
    wait_rise(9);
    fork
      wr(5'd25, 8'd8);
      count_hi(9, 40, c1);
    join
    count_hi(9, 40, c2);
    check("R8 old duty kept", c1, 20);
    check("R8 new duty at wrap", c2, 32);
    rd(5'd25, d); check("R5 shadow rd", d, 8);
    wait_rise(9);
    fork
      wr(5'd25, 8'd2);
      count_hi(9, 40, c1);
    join
    count_hi(9, 40, c2);
    check("R8 second write held", c1, 32);
    check("R8 second write applied", c2, 8);

    // R6: unmasked channel in mode stays immediate
    wr(5'd2, 8'h01); wr(5'd16, 8'd7);
    rd(5'd16, d); check("R5 ch0 duty rd", d, 7);
    idle(84);
    count_hi(0, 40, c1); check("R6 ch0 in mode", c1, 28);

    // R9: reset again mid-run
    @(negedge clk); rst = 1; idle(2); rst = 0;
    check("R9 outputs after reset", int'(pwm_out), 0);
    rd(5'd6, d); check("R9 mode cleared", d, 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule